// File: doc/BRIEF.md
# I2C Slave Register Interface

This block is a slave on a two-wire serial bus. It gives a host controller access to a small bank of byte-wide configuration registers. The block oversamples the bus clock and data lines on a fast system clock and finds START and STOP conditions on the synchronized copies. It accepts only its own fixed 7-bit device address and pulls the data line low in the acknowledge slot of every byte it takes in. A write sets a register pointer and then stores data bytes while the pointer steps forward. A read, usually entered through a repeated START, shifts out register contents from the current pointer.

The data line is open-drain. The block only requests a low level, through `sda_oe_o`. The system clock must run at least eight times faster than the bus clock, which can be as fast as 400 kHz. The register contents are held only while `supply_ok_i` is high. A separate input, `pullup_low_i`, reports that the bus pull-up supply has dropped. While it is high, the bus state machine is held idle, so a collapsing line level cannot be taken for a START.

Top module: `i2c_reg_slave`

## Requirements
- R1: An address byte whose upper seven bits are 1001000 (0x48) is acknowledged: SDA is held low for the whole ninth clock pulse. Address bits arrive MSB first, and bit 0 of the byte is the direction bit (0 = write, 1 = read).
- R2: A falling SDA while SCL is high is a START. From any state, it restarts reception of an address byte, and a byte that was interrupted is dropped. A rising SDA while SCL is high is a STOP and returns the block to idle. The register pointer is kept across both.
- R3: In a write, the first byte after the address loads the register pointer. Each later byte is stored at the pointer, the pointer then steps by one (wrapping at 256), and every byte is acknowledged.
- R4: After an address byte with direction 1, the block shifts out the register at the pointer, MSB first. The pointer steps after each byte. A master acknowledge brings the next byte.
- R5: The block changes its drive of SDA only while SCL is low.
- R6: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START.
- R7: Pointer values of NUM_REGS (8) and above are unmapped. A read there returns 00h. A write there is acknowledged but changes no register.
- R8: While `supply_ok_i` is low, every register is cleared to 00h. While it is high, registers keep their values.
- R9: While `pullup_low_i` is high, the bus logic is held idle. No START is recognised, and no byte is acknowledged.
- R10: An address byte that does not match is not acknowledged. Everything that follows it is ignored until the next START.
- R11: `cfg_o` shows every register, with register i at bits [8i+7:8i]. All registers are 00h after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| supply_ok_i | input | 1 | Supply valid; low clears the register bank |
| pullup_low_i | input | 1 | Pull-up supply below threshold; holds the bus logic idle |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| cfg_o | output | NUM_REGS*8 | Register bank contents |

## Verification
Write bursts cover pointers that stay inside the map and pointers that run past its end. The second case shows that the pointer steps and that stores to unmapped addresses are dropped. Reads through a repeated START, a read that relies on the retained pointer, and a read across the map boundary show that the pointer is kept between transactions and that unmapped reads return zero. A foreign address, a master NACK followed by extra clocks, a START in the middle of a data byte, and a pull-up supply drop in the middle of an address byte each test a different way back to idle. A pulse of the supply-valid input shows clearing and retention. The register outputs are compared with a bench model on every clock, and the data-line drive is watched for changes while SCL is high.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } bus_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o   = scl_sh[STAGES-1];
  assign sda_o   = sda_sh[STAGES-1];
  assign start_o = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o  = scl_o & scl_q & ~sda_q & sda_o;
  assign rise_o  = scl_o & ~scl_q;
  assign fall_o  = ~scl_o & scl_q;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NUM_REGS = 8,
  parameter int AW       = 8,
  parameter int DW       = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [AW-1:0]          raddr_i,
  output logic [DW-1:0]          rdata_o,
  output logic [NUM_REGS*DW-1:0] cfg_o
);
  logic [DW-1:0] reg_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) reg_q[i] <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < NUM_REGS; i++) reg_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (we_i && waddr_i == AW'(i)) reg_q[i] <= wdata_i;
    end
  end

  // unmapped addresses fall through to zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (raddr_i == AW'(i)) rdata_o = reg_q[i];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cfg
    assign cfg_o[g*DW +: DW] = reg_q[g];
  end

  a_r8_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cfg_o == '0));

  a_r7_unmapped_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i >= AW'(NUM_REGS) && !clear_i) |=> $stable(cfg_o));
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pullup_low_i,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              we_o,
  output logic [BYTE_W-1:0] waddr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [BYTE_W-1:0] raddr_o,
  output logic              sda_oe_o
);
  bus_state_e        state_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q, ptr_q;
  logic              ptr_phase_q, rw_q, mack_q, oe_q;

  assign we_o     = (state_q == ST_RX) && fall_i && (bit_cnt_q == 4'd8) &&
                    !ptr_phase_q && !pullup_low_i && !start_i && !stop_i;
  assign waddr_o  = ptr_q;
  assign wdata_o  = shreg_q;
  assign raddr_o  = ptr_q;
  assign sda_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      ptr_q       <= '0;
      ptr_phase_q <= 1'b0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      oe_q        <= 1'b0;
    end else if (pullup_low_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (rise_i) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (fall_i && bit_cnt_q == 4'd8) begin
            if (state_q == ST_ADDR) begin
              if (shreg_q[7:1] == DEV_ADDR) begin
                rw_q        <= shreg_q[0];
                ptr_phase_q <= ~shreg_q[0];
                state_q     <= ST_ACK;
                oe_q        <= 1'b1;
              end else begin
                state_q <= ST_IGNORE;
              end
            end else begin
              if (ptr_phase_q) begin
                ptr_q       <= shreg_q;
                ptr_phase_q <= 1'b0;
              end else begin
                ptr_q <= ptr_q + 1'b1;
              end
              state_q <= ST_ACK;
              oe_q    <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (fall_i) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              shreg_q <= rdata_i;
              ptr_q   <= ptr_q + 1'b1;
              oe_q    <= ~rdata_i[7];
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (fall_i) begin
            if (bit_cnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_MACK;
            end else begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], 1'b0};
              oe_q      <= ~shreg_q[6];
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (rise_i) begin
            mack_q <= ~sda_s_i;
          end else if (fall_i) begin
            if (mack_q) begin
              shreg_q   <= rdata_i;
              ptr_q     <= ptr_q + 1'b1;
              oe_q      <= ~rdata_i[7];
              bit_cnt_q <= '0;
              state_q   <= ST_TX;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  a_r5_sda_steady_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && !pullup_low_i) |=> $stable(oe_q));

  a_r9_pullup_forces_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pullup_low_i |=> (state_q == ST_IDLE && !oe_q));

  a_r2_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !pullup_low_i) |=> (state_q == ST_ADDR && bit_cnt_q == 4'd0));

  a_r6_nack_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MACK && fall_i && !mack_q && !pullup_low_i) |=>
      (state_q == ST_IGNORE && !oe_q));

  a_r10_mismatch_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && fall_i && bit_cnt_q == 4'd8 &&
     shreg_q[7:1] != DEV_ADDR && !pullup_low_i) |=> (!oe_q && state_q == ST_IGNORE));
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h48,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic                       supply_ok_i,
  input  logic                       pullup_low_i,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
  logic scl_s, sda_s, start, stop, rise, fall;
  logic we;
  logic [BYTE_W-1:0] waddr, wdata, raddr, rdata;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .scl_o   (scl_s),
    .sda_o   (sda_s),
    .start_o (start),
    .stop_o  (stop),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pullup_low_i (pullup_low_i),
    .scl_s_i      (scl_s),
    .sda_s_i      (sda_s),
    .start_i      (start),
    .stop_i       (stop),
    .rise_i       (rise),
    .fall_i       (fall),
    .rdata_i      (rdata),
    .we_o         (we),
    .waddr_o      (waddr),
    .wdata_o      (wdata),
    .raddr_o      (raddr),
    .sda_oe_o     (sda_oe_o)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .AW(BYTE_W), .DW(BYTE_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (~supply_ok_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata),
    .cfg_o   (cfg_o)
  );
endmodule

// File: tb/i2c_reg_slave_bench.sv
module i2c_reg_slave_bench;
  localparam int NUM_REGS = 8;
  localparam int Q        = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic supply_ok = 1'b1, pullup_low = 1'b0;
  logic sda_oe;
  logic [NUM_REGS*8-1:0] cfg;
  wire  sda_bus = sda_m & ~sda_oe;

  i2c_reg_slave #(.NUM_REGS(NUM_REGS)) u_i2c_reg_slave (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .supply_ok_i  (supply_ok),
    .pullup_low_i (pullup_low),
    .sda_oe_o     (sda_oe),
    .cfg_o        (cfg)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] mdl [NUM_REGS];
  logic [7:0] mptr = 8'd0;
  bit cmp_en = 1'b1;
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  logic [7:0] wdat [$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NUM_REGS*8-1:0] exp_cfg();
    logic [NUM_REGS*8-1:0] r;
    for (int i = 0; i < NUM_REGS; i++) r[i*8 +: 8] = mdl[i];
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] p);
    return (p < NUM_REGS) ? mdl[p] : 8'h00;
  endfunction

  // per-clock reference comparison
  always @(negedge clk) begin
    cyc++;
    if (cmp_en) chk(cfg == exp_cfg(), "R11 cfg_o vs model", cfg, exp_cfg());
    if (rst_n && scl_m && scl_prev && !pullup_low)
      chk(sda_oe == oe_prev, "R5 drive change with SCL high", sda_oe, oe_prev);
    scl_prev = scl_m;
    oe_prev  = sda_oe;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input bit b, output bit seen);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    seen = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic start_c();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    bit s;
    b = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!mack, s);
  endtask

  task automatic wr_txn(input logic [7:0] p);
    bit a;
    start_c();
    send_byte(8'h90, a); chk(a, "R1 address ack (write)", a, 1);
    send_byte(p, a);     chk(a, "R3 pointer ack", a, 1);
    mptr = p;
    foreach (wdat[k]) begin
      cmp_en = 1'b0;
      send_byte(wdat[k], a);
      chk(a, (mptr < NUM_REGS) ? "R3 data ack" : "R7 unmapped write ack", a, 1);
      if (mptr < NUM_REGS) mdl[mptr] = wdat[k];
      mptr = mptr + 8'd1;
      cmp_en = 1'b1;
    end
    stop_c();
  endtask

  task automatic rd_bytes(input int n);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(b == exp_rd(mptr), (mptr < NUM_REGS) ? "R4 read data" : "R7 unmapped read", b, exp_rd(mptr));
      mptr = mptr + 8'd1;
    end
  endtask

  task automatic rd_txn(input logic [7:0] p, input int n);
    bit a;
    start_c();
    send_byte(8'h90, a); chk(a, "R1 address ack", a, 1);
    send_byte(p, a);     chk(a, "R3 pointer ack", a, 1);
    mptr = p;
    start_c();
    send_byte(8'h91, a); chk(a, "R2 R4 address ack after repeated start", a, 1);
    rd_bytes(n);
    stop_c();
  endtask

  initial begin
    bit a;
    logic [7:0] b;
    for (int i = 0; i < NUM_REGS; i++) mdl[i] = 8'h00;
    tick(4);
    chk(sda_oe == 1'b0, "R11 reset sda release", sda_oe, 0);
    chk(cfg == '0, "R11 reset registers", cfg, 0);
    rst_n = 1'b1;
    tick(10);

    // R3 burst write inside the map
    wdat.delete(); wdat.push_back(8'hA5); wdat.push_back(8'h3C); wdat.push_back(8'h7E);
    wr_txn(8'd1);
    rd_txn(8'd1, 3);

    // R7 burst running past the map end
    wdat.delete();
    wdat.push_back(8'h11); wdat.push_back(8'h22); wdat.push_back(8'h33); wdat.push_back(8'h44);
    wr_txn(8'd6);
    rd_txn(8'd5, 5);

    // R10 foreign address
    start_c();
    send_byte(8'h92, a); chk(!a, "R10 foreign address not acked", a, 0);
    send_byte(8'h00, a); chk(!a, "R10 byte after mismatch ignored", a, 0);
    stop_c();
    start_c();
    send_byte(8'h93, a); chk(!a, "R10 foreign read not acked", a, 0);
    recv_byte(1'b0, b);  chk(b == 8'hFF, "R10 no drive after mismatch", b, 8'hFF);
    stop_c();

    // R6 master NACK releases SDA
    start_c();
    send_byte(8'h90, a); send_byte(8'd1, a);
    mptr = 8'd1;
    start_c();
    send_byte(8'h91, a); chk(a, "R4 read address ack", a, 1);
    rd_bytes(1);
    recv_byte(1'b0, b);  chk(b == 8'hFF, "R6 released after NACK", b, 8'hFF);
    stop_c();
    // pointer retained: read without setting it
    start_c();
    send_byte(8'h91, a); chk(a, "R4 read at retained pointer ack", a, 1);
    rd_bytes(2);
    stop_c();

    // R2 START inside a data byte drops that byte
    start_c();
    send_byte(8'h90, a); send_byte(8'd3, a);
    mptr = 8'd3;
    for (int i = 0; i < 4; i++) clk_bit(1'b0, a);
    start_c();
    send_byte(8'h91, a); chk(a, "R2 restart ack", a, 1);
    rd_bytes(1);
    stop_c();

    // R9 pull-up supply drop
    start_c();
    clk_bit(1'b1, a); clk_bit(1'b0, a); clk_bit(1'b0, a);
    pullup_low = 1'b1;
    clk_bit(1'b1, a); clk_bit(1'b0, a); clk_bit(1'b0, a); clk_bit(1'b0, a); clk_bit(1'b0, a);
    clk_bit(1'b1, a); chk(a, "R9 no ack after supply drop", !a, 0);
    stop_c();
    start_c();
    send_byte(8'h90, a); chk(!a, "R9 start ignored while low", a, 0);
    stop_c();
    pullup_low = 1'b0;
    tick(10);
    wdat.delete(); wdat.push_back(8'h5A);
    wr_txn(8'd0);
    rd_txn(8'd0, 2);

    // R8 supply-valid clears registers
    chk(cfg != '0, "R8 retention while supply valid", cfg, exp_cfg());
    cmp_en = 1'b0;
    supply_ok = 1'b0;
    tick(3);
    for (int i = 0; i < NUM_REGS; i++) mdl[i] = 8'h00;
    chk(cfg == '0, "R8 cleared on supply loss", cfg, 0);
    cmp_en = 1'b1;
    supply_ok = 1'b1;
    tick(5);
    rd_txn(8'd0, 3);

    tick(20);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule